// File: doc/BRIEF.md
# Multiplexed-bus host register port

This block is the slave side of a byte-wide host bus on which a register number and its data share the same eight wires, one after the other. The host first presents a register number and pulses an address-latch strobe; the block keeps that number. The host then pulses an active-low write strobe to load a byte into the selected register, or holds an active-low read strobe low to have the block drive the selected register's value back onto the bus. An active-high chip select must be high for either strobe to count.

Behind the port sits a bank of 32 byte locations. By default locations 0 to 11 are read/write control registers, 12 to 15 are write-only control registers (they drive the control outputs but read back as zero), 16 to 23 are read-only status locations that reflect the status input, and 24 to 31 are unused. A second, already-synchronous host port can also write the control registers; when both ports write the same register on the same clock, this port wins. All bus strobes and data are passed through two-stage synchronisers into the system clock domain before use, except the bus output enable, which follows the pins directly.

Top module: `mux_regport`

## Requirements
- R1: After reset every byte of `ctrl_q` is 0x00 and `bus_oe` is low while the read strobe is inactive.
- R2: While `ale` is high the bus value is captured as the register number; only its low 5 bits select a location, so 0x2A selects location 10, and the number is held unchanged while `ale` is low.
- R3: With `cs` high, a byte on the bus while `wr_n` is low is written into the selected control register when `wr_n` rises; the new value appears on `ctrl_q` (byte n at bits 8n+7:8n) at the third rising clock edge after the strobe rises.
- R4: `bus_oe` is high exactly while `cs` is high and `rd_n` is low; then `bus_out` carries the selected location's read value.
- R5: While `cs` is low, a pulse on `wr_n` changes no register and a low `rd_n` leaves `bus_oe` low.
- R6: Locations 12 to 15 are write-only: writes reach `ctrl_q`, but reads return 0x00.
- R7: Locations 16 to 23 read back the matching byte of `stat_in` (byte n at bits 8n+7:8n); writes to them are ignored.
- R8: Locations 24 to 31 are unused: writes change no output and reads return 0x00.
- R9: `h2_we` high at a rising clock edge writes `h2_wdata` into control register `h2_addr`; if this port commits a write to the same register at the same edge, this port's data is kept.
- R10: A write strobe without a new address-latch pulse writes the last latched location again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, gates both strobes |
| ale | input | 1 | Address latch strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_in | input | 8 | Multiplexed address/data bus, input side |
| bus_out | output | 8 | Read data driven toward the bus |
| bus_oe | output | 1 | Bus drive enable; bus is high impedance when low |
| h2_we | input | 1 | Second port write enable |
| h2_addr | input | 5 | Second port register number |
| h2_wdata | input | 8 | Second port write data |
| stat_in | input | 256 | Status bytes, byte n at bits 8n+7:8n |
| ctrl_q | output | 256 | Control register contents, byte n at bits 8n+7:8n |

## Verification
The hardest case to reach is a write from the second port landing on exactly the clock edge where a bus write commits to the same register, because the bus commit happens three synchroniser edges after the strobe pin rises. The stimulus raises `wr_n` on a falling clock edge, counts two further falling edges, and pulses `h2_we` for the one cycle that contains the commit edge. A behavioural model in the bench replays the pin history through a two-entry delay queue and compares every control byte and the read bus on every clock, so any slip of one cycle in the commit or the arbitration shows up.

// File: rtl/mux_regport.sv
module mux_regport #(
  parameter int NREG = 32,
  parameter int DW = 8,
  parameter logic [NREG-1:0] CTRL_MASK = 32'h0000_FFFF,
  parameter logic [NREG-1:0] WO_MASK   = 32'h0000_F000,
  parameter logic [NREG-1:0] STAT_MASK = 32'h00FF_0000,
  localparam int AW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             ale,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [DW-1:0]    bus_in,
  output logic [DW-1:0]    bus_out,
  output logic             bus_oe,
  input  logic             h2_we,
  input  logic [AW-1:0]    h2_addr,
  input  logic [DW-1:0]    h2_wdata,
  input  logic [NREG*DW-1:0] stat_in,
  output logic [NREG*DW-1:0] ctrl_q
);

  logic [1:0]    ale_y, cs_y, wr_y;
  logic [DW-1:0] bus_y, bus_s;
  logic          wr_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] rd_val;

  wire ale_s = ale_y[1];
  wire cs_s  = cs_y[1];
  wire wr_s  = wr_y[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ale_y <= '0;
      cs_y  <= '0;
      wr_y  <= '1;
      bus_y <= '0;
      bus_s <= '0;
      wr_d  <= 1'b1;
    end else begin
      ale_y <= {ale_y[0], ale};
      cs_y  <= {cs_y[0], cs};
      wr_y  <= {wr_y[0], wr_n};
      bus_y <= bus_in;
      bus_s <= bus_y;
      wr_d  <= wr_s;
    end

  wire commit  = cs_s & wr_s & ~wr_d;
  wire mux_hit = commit & CTRL_MASK[addr_q];
  wire h2_hit  = h2_we & CTRL_MASK[h2_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      if (ale_s) addr_q <= bus_s[AW-1:0];
      if (cs_s && !wr_s) wdat_q <= bus_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (mux_hit && addr_q == AW'(i)) regs[i] <= wdat_q;
        else if (h2_hit && h2_addr == AW'(i)) regs[i] <= h2_wdata;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign ctrl_q[g*DW +: DW] = regs[g];
  end

  always_comb begin
    rd_val = '0;
    if (STAT_MASK[addr_q]) rd_val = stat_in[addr_q*DW +: DW];
    else if (CTRL_MASK[addr_q] && !WO_MASK[addr_q]) rd_val = regs[addr_q];
  end

  assign bus_out = rd_val;
  assign bus_oe  = cs & ~rd_n;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_s |=> $stable(addr_q)); // R2
  AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mux_hit |=> regs[$past(addr_q)] == $past(wdat_q)); // R3
  AST_CS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !h2_we) |=> $stable(ctrl_q)); // R5
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && WO_MASK[addr_q]) |-> bus_out == '0); // R6
  AST_ARB_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_hit && h2_hit && h2_addr == addr_q) |=> regs[$past(h2_addr)] != $past(h2_wdata) || $past(h2_wdata) == $past(wdat_q)); // R9

endmodule

// File: tb/sim_mux_regport.sv
module sim_mux_regport;
  logic clk = 0, rst_n = 0;
  logic cs = 0, ale = 0, wr_n = 1, rd_n = 1;
  logic [7:0] bus_in = 0;
  logic [7:0] bus_out;
  logic bus_oe;
  logic h2_we = 0;
  logic [4:0] h2_addr = 0;
  logic [7:0] h2_wdata = 0;
  logic [255:0] stat_in;
  logic [255:0] ctrl_q;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mux_regport u0 (.clk, .rst_n, .cs, .ale, .wr_n, .rd_n, .bus_in, .bus_out, .bus_oe,
                  .h2_we, .h2_addr, .h2_wdata, .stat_in, .ctrl_q);

  initial for (int i = 0; i < 32; i++) stat_in[i*8 +: 8] = (i == 17) ? 8'h9C : 8'(i*3 + 1);

  function automatic bit is_ctrl(int a); return a < 16; endfunction
  function automatic bit is_wo(int a);   return a >= 12 && a < 16; endfunction
  function automatic bit is_stat(int a); return a >= 16 && a < 24; endfunction

  logic [7:0] m_reg [32];
  logic [10:0] pipe [$];
  int m_addr = 0;
  logic [7:0] m_wdat = 0;
  logic m_prev_wr = 1;

  always @(posedge clk) if (rst_n) begin
    logic [10:0] e;
    bit hit_mux;
    hit_mux = 0;
    pipe.push_back({ale, cs, wr_n, bus_in});
    if (pipe.size() > 2) begin
      e = pipe.pop_front();
      if (e[9] && e[8] && !m_prev_wr && is_ctrl(m_addr)) hit_mux = 1;
      if (h2_we && is_ctrl(int'(h2_addr))) m_reg[h2_addr] = h2_wdata;
      if (hit_mux) m_reg[m_addr] = m_wdat;
      if (e[10]) m_addr = int'(e[4:0]);
      if (e[9] && !e[8]) m_wdat = e[7:0];
      m_prev_wr = e[8];
    end
  end

  function automatic logic [7:0] m_read();
    if (is_stat(m_addr)) return stat_in[m_addr*8 +: 8];
    if (is_ctrl(m_addr) && !is_wo(m_addr)) return m_reg[m_addr];
    return 8'h00;
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic [255:0] mv;
    for (int i = 0; i < 32; i++) mv[i*8 +: 8] = m_reg[i];
    checks++;
    if (ctrl_q !== mv) begin
      fails++;
      $display("FAIL R3 model ctrl_q act=%h exp=%h", ctrl_q, mv);
    end
    checks++;
    if (bus_oe !== (cs && !rd_n) || (bus_oe && bus_out !== m_read())) begin
      fails++;
      $display("FAIL R4 model bus act=%b/%h exp=%b/%h", bus_oe, bus_out, cs && !rd_n, m_read());
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_addr(logic [7:0] a);
    @(negedge clk) bus_in = a; ale = 1;
    repeat (3) @(negedge clk);
    ale = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_cycle(logic [7:0] d, logic csv);
    @(negedge clk) cs = csv; bus_in = d; wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (3) @(negedge clk);
    cs = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_val(string tag, logic [7:0] exp);
    @(negedge clk) cs = 1; rd_n = 0;
    @(negedge clk);
    chk(tag, {7'd0, bus_oe}, 8'h01);
    chk(tag, bus_out, exp);
    rd_n = 1; cs = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl_q zero", 8'(|ctrl_q), 8'h00);
    chk("R1 oe low", {7'd0, bus_oe}, 8'h00);

    set_addr(8'h03); wr_cycle(8'h5A, 1);
    chk("R3 byte3", ctrl_q[3*8 +: 8], 8'h5A);
    rd_val("R4 read3", 8'h5A);
    @(negedge clk) cs = 1;
    @(negedge clk) chk("R4 oe low rd_n high", {7'd0, bus_oe}, 8'h00);
    cs = 0;

    set_addr(8'h2A); wr_cycle(8'hC3, 1);
    chk("R2 byte10 from 0x2A", ctrl_q[10*8 +: 8], 8'hC3);

    set_addr(8'h04); wr_cycle(8'hFF, 0);
    chk("R5 byte4 unchanged", ctrl_q[4*8 +: 8], 8'h00);
    @(negedge clk) rd_n = 0;
    @(negedge clk) chk("R5 oe low cs low", {7'd0, bus_oe}, 8'h00);
    rd_n = 1;

    set_addr(8'h0D); wr_cycle(8'h77, 1);
    chk("R6 byte13 drives", ctrl_q[13*8 +: 8], 8'h77);
    rd_val("R6 read13 zero", 8'h00);

    set_addr(8'h11); wr_cycle(8'h11, 1);
    chk("R7 byte17 not written", ctrl_q[17*8 +: 8], 8'h00);
    rd_val("R7 read17 status", 8'h9C);

    set_addr(8'h1C); wr_cycle(8'hEE, 1);
    chk("R8 byte28 not written", ctrl_q[28*8 +: 8], 8'h00);
    rd_val("R8 read28 zero", 8'h00);

    @(negedge clk) h2_we = 1; h2_addr = 5; h2_wdata = 8'h33;
    @(negedge clk) h2_we = 0;
    chk("R9 h2 byte5", ctrl_q[5*8 +: 8], 8'h33);

    set_addr(8'h06);
    @(negedge clk) cs = 1; bus_in = 8'hA1; wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    @(negedge clk);
    h2_we = 1; h2_addr = 6; h2_wdata = 8'h5C;
    @(negedge clk) h2_we = 0;
    chk("R9 collision byte6", ctrl_q[6*8 +: 8], 8'hA1);
    repeat (2) @(negedge clk);
    cs = 0;

    set_addr(8'h03);
    wr_cycle(8'h11, 1);
    wr_cycle(8'h66, 1);
    chk("R10 reuse addr byte3", ctrl_q[3*8 +: 8], 8'h66);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule